// File: doc/BRIEF.md
# Fetch-Stage Dynamic Branch Predictor

This block predicts, in the same cycle a fetch address is presented, whether the instruction there is a taken branch and which address to fetch next. Direction comes from a table of two-bit saturating counters indexed by low address bits. The taken-path address comes from a small direct-mapped target buffer whose entries carry an address tag. When the target buffer has no matching entry, a static rule based on the sign of the branch offset reported by predecode decides the direction.

The execute stage reports each resolved branch through an update port. The report carries the branch address, the real outcome, the real target and a flag saying the earlier prediction was wrong. The update trains the counter, fills the target buffer for taken branches, and on a misprediction raises a redirect request in the same cycle. The redirect steers the next fetch address to the correct path.

Top module: `branch_predictor`

## Requirements
- R1: After synchronous reset every direction counter holds 01 (weakly not taken) and every target buffer entry is invalid, so a branch lookup uses the static rule.
- R2: Counter codes are 00 strongly not taken, 01 weakly not taken, 10 weakly taken and 11 strongly taken. On a target buffer hit the direction is taken exactly when bit 1 of the counter is 1.
- R3: A resolved taken branch moves its counter one step toward 11 and a not-taken one moves it one step toward 00. The counter stays at 11 on taken and at 00 on not taken.
- R4: When a branch lookup hits the target buffer and the direction is taken, next_pc equals the stored target in the same cycle.
- R5: When a branch lookup misses the target buffer, pred_taken equals pd_offset_neg (backward taken, forward not taken) and next_pc is fetch_pc + 4, because no target is known.
- R6: When a branch that hits the target buffer is predicted not taken, next_pc is fetch_pc + 4.
- R7: When pd_branch is 0, pred_taken is 0 and next_pc is fetch_pc + 4, whatever the tables hold.
- R8: When upd_valid and upd_mispredict are both 1, redirect is 1 in that cycle. next_pc then equals upd_target if upd_taken is 1, else upd_pc + 4, overriding any prediction. Otherwise redirect is 0.
- R9: A resolved taken branch writes its target buffer entry (index upd_pc[5:2], tag upd_pc[31:6], target upd_target) and marks it valid. A not-taken resolution leaves the buffer unchanged. A lookup hits only when the indexed entry is valid and its tag equals fetch_pc[31:6].
- R10: An update and a lookup in the same cycle see the table contents from before the update. The update takes effect at the next clock edge.
- R11: The counter used for an address is selected by address bits [7:2], so addresses equal in those bits share one counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pd_branch | input | 1 | Predecode: instruction at fetch_pc is a conditional branch |
| pd_offset_neg | input | 1 | Predecode: branch offset is negative (backward) |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |
| upd_target | input | 32 | Actual target of the resolved branch |
| upd_mispredict | input | 1 | The earlier prediction for this branch was wrong |
| pred_taken | output | 1 | Predicted direction for the instruction at fetch_pc |
| next_pc | output | 32 | Address to fetch next (redirect address when redirect is 1) |
| redirect | output | 1 | Request to discard the speculative path and restart at next_pc |

## Verification
Every output is combinational from the current inputs and the stored tables, so a prediction or a redirect is due in the same cycle as its stimulus. A table update becomes visible only to lookups after the next rising edge. The bench therefore drives inputs on the falling edge and compares the outputs 2 ns later, against a model that still holds the old table contents. It applies the update to its model only after the rising edge that commits it. This ordering also covers the same-cycle update-and-lookup case.

// File: rtl/bp_pkg.sv
package bp_pkg;

    localparam int PC_W        = 32;
    localparam int INSN_ALIGN  = 2;
    localparam int INSN_BYTES  = 1 << INSN_ALIGN;
    localparam int DIR_IDX_W   = 6;
    localparam int TB_IDX_W    = 4;
    localparam int DIR_ENTRIES = 1 << DIR_IDX_W;
    localparam int TB_ENTRIES  = 1 << TB_IDX_W;
    localparam int TAG_W       = PC_W - TB_IDX_W - INSN_ALIGN;

    typedef logic [PC_W-1:0]      pc_t;
    typedef logic [DIR_IDX_W-1:0] dir_idx_t;
    typedef logic [TB_IDX_W-1:0]  tb_idx_t;
    typedef logic [TAG_W-1:0]     tb_tag_t;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

    typedef struct packed {
        logic    valid;
        tb_tag_t tag;
        pc_t     target;
    } tb_entry_t;

    function automatic ctr_e ctr_next(input ctr_e cur, input logic taken);
        ctr_e nxt;
        case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            default: nxt = taken ? CTR_ST  : CTR_WT;
        endcase
        return nxt;
    endfunction

    function automatic dir_idx_t dir_index(input pc_t pc);
        return pc[INSN_ALIGN +: DIR_IDX_W];
    endfunction

    function automatic tb_idx_t tb_index(input pc_t pc);
        return pc[INSN_ALIGN +: TB_IDX_W];
    endfunction

    function automatic tb_tag_t tb_tag(input pc_t pc);
        return pc[PC_W-1 -: TAG_W];
    endfunction

    function automatic pc_t seq_next(input pc_t pc);
        return pc + PC_W'(INSN_BYTES);
    endfunction

endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table
    import bp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  dir_idx_t rd_idx,
    output ctr_e     rd_ctr,
    input  logic     wr_en,
    input  dir_idx_t wr_idx,
    input  logic     wr_taken
);

    ctr_e ctr_q [DIR_ENTRIES];

    for (genvar g = 0; g < DIR_ENTRIES; g++) begin : g_ctr
        always_ff @(posedge clk) begin
            if (rst) begin
                ctr_q[g] <= CTR_WNT;
            end else if (wr_en && (wr_idx == DIR_IDX_W'(g))) begin
                ctr_q[g] <= ctr_next(ctr_q[g], wr_taken);
            end
        end
    end

    assign rd_ctr = ctr_q[rd_idx];

    a_r3_step_up: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && ctr_q[wr_idx] != CTR_ST)
        |=> (ctr_q[$past(wr_idx)] == ctr_e'($past(ctr_q[wr_idx]) + 2'd1)));

    a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && ctr_q[wr_idx] != CTR_SNT)
        |=> (ctr_q[$past(wr_idx)] == ctr_e'($past(ctr_q[wr_idx]) - 2'd1)));

    a_r3_sat_high: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && ctr_q[wr_idx] == CTR_ST)
        |=> (ctr_q[$past(wr_idx)] == CTR_ST));

    a_r3_sat_low: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && ctr_q[wr_idx] == CTR_SNT)
        |=> (ctr_q[$past(wr_idx)] == CTR_SNT));

endmodule

// File: rtl/bp_target_buf.sv
module bp_target_buf
    import bp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  pc_t  lk_pc,
    output logic lk_hit,
    output pc_t  lk_target,
    input  logic wr_en,
    input  pc_t  wr_pc,
    input  pc_t  wr_target
);

    tb_entry_t ent_q [TB_ENTRIES];
    tb_idx_t   wr_idx;
    tb_entry_t wr_ent;
    tb_entry_t lk_ent;

    assign wr_idx        = tb_index(wr_pc);
    assign wr_ent.valid  = 1'b1;
    assign wr_ent.tag    = tb_tag(wr_pc);
    assign wr_ent.target = wr_target;

    for (genvar g = 0; g < TB_ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g] <= '0;
            end else if (wr_en && (wr_idx == TB_IDX_W'(g))) begin
                ent_q[g] <= wr_ent;
            end
        end
    end

    assign lk_ent    = ent_q[tb_index(lk_pc)];
    assign lk_hit    = lk_ent.valid && (lk_ent.tag == tb_tag(lk_pc));
    assign lk_target = lk_ent.target;

    a_r9_alloc_valid: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ent_q[$past(wr_idx)].valid
                   && ent_q[$past(wr_idx)].tag == tb_tag($past(wr_pc))
                   && ent_q[$past(wr_idx)].target == $past(wr_target)));

    a_r9_no_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (ent_q[$past(wr_idx)] == $past(ent_q[wr_idx])));

endmodule

// File: rtl/bp_fetch_select.sv
module bp_fetch_select
    import bp_pkg::*;
(
    input  pc_t  fetch_pc,
    input  logic pd_branch,
    input  logic pd_offset_neg,
    input  logic tb_hit,
    input  pc_t  tb_target,
    input  ctr_e dir_ctr,
    input  logic upd_valid,
    input  pc_t  upd_pc,
    input  logic upd_taken,
    input  pc_t  upd_target,
    input  logic upd_mispredict,
    output logic pred_taken,
    output pc_t  next_pc,
    output logic redirect
);

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_DYNAMIC,
        SRC_STATIC
    } src_e;

    src_e src;
    pc_t  spec_pc;
    pc_t  fix_pc;

    always_comb begin
        if (!pd_branch)  src = SRC_NONE;
        else if (tb_hit) src = SRC_DYNAMIC;
        else             src = SRC_STATIC;
    end

    always_comb begin
        pred_taken = 1'b0;
        spec_pc    = seq_next(fetch_pc);
        case (src)
            SRC_DYNAMIC: begin
                pred_taken = dir_ctr[1];
                if (dir_ctr[1]) spec_pc = tb_target;
            end
            SRC_STATIC: pred_taken = pd_offset_neg;
            default:    pred_taken = 1'b0;
        endcase
    end

    assign redirect = upd_valid && upd_mispredict;
    assign fix_pc   = upd_taken ? upd_target : seq_next(upd_pc);
    assign next_pc  = redirect ? fix_pc : spec_pc;

endmodule

// File: rtl/branch_predictor.sv
module branch_predictor
    import bp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] fetch_pc,
    input  logic        pd_branch,
    input  logic        pd_offset_neg,
    input  logic        upd_valid,
    input  logic [31:0] upd_pc,
    input  logic        upd_taken,
    input  logic [31:0] upd_target,
    input  logic        upd_mispredict,
    output logic        pred_taken,
    output logic [31:0] next_pc,
    output logic        redirect
);

    ctr_e dir_ctr;
    logic tb_hit;
    pc_t  tb_target;

    bp_dir_table u_dir (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (dir_index(fetch_pc)),
        .rd_ctr   (dir_ctr),
        .wr_en    (upd_valid),
        .wr_idx   (dir_index(upd_pc)),
        .wr_taken (upd_taken)
    );

    bp_target_buf u_tb (
        .clk       (clk),
        .rst       (rst),
        .lk_pc     (fetch_pc),
        .lk_hit    (tb_hit),
        .lk_target (tb_target),
        .wr_en     (upd_valid && upd_taken),
        .wr_pc     (upd_pc),
        .wr_target (upd_target)
    );

    bp_fetch_select u_sel (
        .fetch_pc       (fetch_pc),
        .pd_branch      (pd_branch),
        .pd_offset_neg  (pd_offset_neg),
        .tb_hit         (tb_hit),
        .tb_target      (tb_target),
        .dir_ctr        (dir_ctr),
        .upd_valid      (upd_valid),
        .upd_pc         (upd_pc),
        .upd_taken      (upd_taken),
        .upd_target     (upd_target),
        .upd_mispredict (upd_mispredict),
        .pred_taken     (pred_taken),
        .next_pc        (next_pc),
        .redirect       (redirect)
    );

    a_r8_redirect_req: assert property (@(posedge clk) disable iff (rst)
        redirect == (upd_valid && upd_mispredict));

    a_r8_redirect_taken: assert property (@(posedge clk) disable iff (rst)
        (redirect && upd_taken) |-> (next_pc == upd_target));

    a_r7_nonbranch: assert property (@(posedge clk) disable iff (rst)
        (!pd_branch && !redirect) |-> (!pred_taken && next_pc == fetch_pc + 32'd4));

    a_r4_hit_target: assert property (@(posedge clk) disable iff (rst)
        (pd_branch && tb_hit && dir_ctr[1] && !redirect) |-> (pred_taken && next_pc == tb_target));

    a_r5_static: assert property (@(posedge clk) disable iff (rst)
        (pd_branch && !tb_hit && !redirect) |-> (pred_taken == pd_offset_neg && next_pc == fetch_pc + 32'd4));

endmodule

// File: tb/tb_branch_predictor.sv
`timescale 1ns/1ps
module tb_branch_predictor;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] fetch_pc;
    logic        pd_branch, pd_offset_neg;
    logic        upd_valid, upd_taken, upd_mispredict;
    logic [31:0] upd_pc, upd_target;
    logic        pred_taken, redirect;
    logic [31:0] next_pc;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [1:0]  m_ctr [64];
    logic        m_v   [16];
    logic [25:0] m_tag [16];
    logic [31:0] m_tgt [16];

    always #10 clk = ~clk;

    branch_predictor dut (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pd_branch(pd_branch),
        .pd_offset_neg(pd_offset_neg), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_target(upd_target), .upd_mispredict(upd_mispredict),
        .pred_taken(pred_taken), .next_pc(next_pc), .redirect(redirect)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 64; i++) m_ctr[i] = 2'b01;
        for (int i = 0; i < 16; i++) begin
            m_v[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
        end
    endtask

    // One cycle: drive at falling edge, compare 2 ns later, commit model after rising edge
    task automatic step(input string tag, input logic [31:0] fpc, input logic br, input logic neg,
                        input logic uv, input logic [31:0] upc, input logic ut,
                        input logic [31:0] utgt, input logic um);
        logic        hit, et, er;
        logic [31:0] enp;
        logic [1:0]  dc;
        int          ti, ci;
        @(negedge clk);
        fetch_pc = fpc; pd_branch = br; pd_offset_neg = neg;
        upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utgt; upd_mispredict = um;
        #2;
        ti  = int'(fpc[5:2]);
        ci  = int'(fpc[7:2]);
        dc  = m_ctr[ci];
        hit = br && m_v[ti] && (m_tag[ti] == fpc[31:6]);
        if (!br)     et = 1'b0;
        else if (hit) et = dc[1];
        else         et = neg;
        enp = (hit && et) ? m_tgt[ti] : fpc + 32'd4;
        er  = uv && um;
        if (er) enp = ut ? utgt : upc + 32'd4;
        check(tag, "pred_taken", {31'd0, pred_taken}, {31'd0, et});
        check(tag, "next_pc", next_pc, enp);
        check(tag, "redirect", {31'd0, redirect}, {31'd0, er});
        @(posedge clk);
        if (uv) begin
            ci = int'(upc[7:2]);
            if (ut && m_ctr[ci] != 2'b11) m_ctr[ci] = m_ctr[ci] + 2'd1;
            if (!ut && m_ctr[ci] != 2'b00) m_ctr[ci] = m_ctr[ci] - 2'd1;
            if (ut) begin
                ti = int'(upc[5:2]);
                m_v[ti] = 1'b1; m_tag[ti] = upc[31:6]; m_tgt[ti] = utgt;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        logic [31:0] pc;
        logic [31:0] tgt;
        logic        pat [8];
        rst = 1'b1;
        fetch_pc = '0; pd_branch = 0; pd_offset_neg = 0;
        upd_valid = 0; upd_pc = '0; upd_taken = 0; upd_target = '0; upd_mispredict = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 R5: empty buffer after reset, static rule both signs
        for (int i = 0; i < 16; i++) begin
            step("R1", 32'h0000_2000 + 32'(i * 4), 1'b1, i[0], 0, '0, 0, '0, 0);
        end
        // R7: non-branch
        step("R7", 32'h0000_3004, 1'b0, 1'b1, 0, '0, 0, '0, 0);

        pat[0] = 1; pat[1] = 1; pat[2] = 0; pat[3] = 0;
        pat[4] = 0; pat[5] = 0; pat[6] = 1; pat[7] = 1;

        // R2 R3 R4 R6 R8 R9 R11: sweep every counter index through a full walk
        for (int i = 0; i < 64; i++) begin
            pc  = 32'h0001_0000 + 32'(i << 2);
            tgt = 32'h8000_0000 + 32'(i << 4);
            step("R9", pc, 1'b1, 1'b0, 1, pc, 1, tgt, i[0]);      // allocate, counter 01->10
            step("R4", pc, 1'b1, 1'b0, 0, '0, 0, '0, 0);          // weakly taken hit
            for (int k = 0; k < 8; k++) begin
                step("R3", 32'h0000_0100, 1'b1, 1'b0, 1, pc, pat[k], tgt, i[1] ^ k[0]);
                step("R2", pc, 1'b1, 1'b1, 0, '0, 0, '0, 0);
            end
            step("R7", pc, 1'b0, 1'b1, 0, '0, 0, '0, 0);          // hit ignored for non-branch
        end

        // R11: alias on bits [7:2], different upper bits share counter, buffer tag misses
        step("R11", 32'h0002_0040, 1'b1, 1'b0, 1, 32'h0002_0040, 1, 32'h0000_9000, 0);
        step("R11", 32'h0002_0040, 1'b1, 1'b0, 1, 32'h0002_0040, 1, 32'h0000_9000, 0);
        step("R11", 32'h0003_0040, 1'b1, 1'b0, 0, '0, 0, '0, 0);  // tag miss -> static not taken
        step("R11", 32'h0003_0040, 1'b1, 1'b0, 1, 32'h0003_0040, 1, 32'h0000_A000, 1);
        step("R11", 32'h0002_0040, 1'b1, 1'b1, 0, '0, 0, '0, 0);  // evicted -> static
        step("R11", 32'h0003_0040, 1'b1, 1'b0, 0, '0, 0, '0, 0);

        // R9: not-taken resolution does not allocate
        step("R9", 32'h0000_0200, 1'b1, 1'b0, 1, 32'h0004_0080, 0, 32'h0000_B000, 1);
        step("R9", 32'h0004_0080, 1'b1, 1'b0, 0, '0, 0, '0, 0);

        // R10: update and lookup of the same entry in one cycle
        step("R10", 32'h0005_00C0, 1'b1, 1'b0, 1, 32'h0005_00C0, 1, 32'h0000_C000, 0);
        step("R10", 32'h0005_00C0, 1'b1, 1'b0, 1, 32'h0005_00C0, 1, 32'h0000_C100, 0);
        step("R10", 32'h0005_00C0, 1'b1, 1'b0, 1, 32'h0005_00C0, 0, 32'h0000_C200, 1);
        step("R10", 32'h0005_00C0, 1'b1, 1'b0, 0, '0, 0, '0, 0);

        // R8 and mixed traffic: pseudo-random addresses in a narrow window
        lfsr = 32'h1234_5679;
        for (int n = 0; n < 400; n++) begin
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            step("R8", {24'h0006_00, lfsr[31:28], lfsr[3:2], 2'b00}, lfsr[20], lfsr[21], lfsr[22],
                 {24'h0006_00, lfsr[27:24], lfsr[5:4], 2'b00}, lfsr[23], {16'h00A0, lfsr[15:0]}, lfsr[19]);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule